// File: doc/BRIEF.md
# UART Modem Control and Loopback

This block holds the modem control register of a 16550-style UART and derives from it every modem and serial pin at the UART boundary. Software writes a 16-bit control word through a simple write port. Seven bits are implemented. They set the four active-low modem control pins, put the UART into diagnostic loopback, switch on automatic request-to-send flow control, and select infrared signalling.

In normal operation the transmitter's data reaches the serial pins, and the received pins reach the receiver's inputs. The external modem status inputs cross a two-flop synchronizer before the modem status logic sees them. In loopback every external pin is parked, and the data and control signals are turned around inside the block. The receiver and the modem status logic keep working on the looped signals, so the interrupt logic runs unchanged. In infrared loopback the turned-around data is inverted.

Top module: `uart_modem_ctrl`

## Requirements
- R1: While reset is asserted and after it, the control word reads 0, and dtr_n, rts_n, out1_n and out2_n are high.
- R2: A cycle with wr_en high stores wr_data[6:0] into the control word, which reads back on rd_data from the next cycle. wr_data[15:7] is ignored, and rd_data[15:7] is always 0. The bit layout is: bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2, bit 4 loopback, bit 5 auto flow, bit 6 infrared.
- R3: Outside loopback, dtr_n, out1_n and out2_n are each the inverse of their control bit (0, 2 and 3). rts_n is the inverse of bit 1, subject to R4.
- R4: Outside loopback, rts_n is forced high when bit 5, fifo_en and rx_above_trig are all 1. If any of the three is 0, rts_n follows bit 1 alone.
- R5: Outside loopback, sout equals ser_tx, sir_out_n equals ir_tx_n, rx_serial equals sin and ir_rx equals sir_in.
- R6: In loopback with bit 6 at 0, sout is held high, sir_out_n is held low, rx_serial equals ser_tx and ir_rx is 0.
- R7: In loopback with bit 6 at 1, sout is held high, sir_out_n is held low, ir_rx equals the inverse of ir_tx_n and rx_serial is held high.
- R8: In loopback, dtr_n, rts_n, out1_n and out2_n are all held high.
- R9: In loopback, the external modem inputs have no effect. dsr_n_int, cts_n_int, ri_n_int and dcd_n_int are the inverses of DTR, RTS, OUT1 and OUT2. The RTS value looped here is not gated by R4.
- R10: Outside loopback, dsr_n_int, cts_n_int, ri_n_int and dcd_n_int equal dsr_n, cts_n, ri_n and dcd_n as sampled two clock edges earlier. The synchronizer resets to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word write data |
| rd_data | output | 16 | Current control word |
| fifo_en | input | 1 | FIFOs enabled |
| rx_above_trig | input | 1 | Receive FIFO is above its trigger level |
| ser_tx | input | 1 | Serial data from the transmitter |
| ir_tx_n | input | 1 | Infrared data from the transmitter, active low |
| sin | input | 1 | Serial receive pin |
| sir_in | input | 1 | Infrared receive pin |
| dsr_n | input | 1 | External data set ready, active low |
| cts_n | input | 1 | External clear to send, active low |
| ri_n | input | 1 | External ring indicator, active low |
| dcd_n | input | 1 | External carrier detect, active low |
| sout | output | 1 | Serial transmit pin |
| sir_out_n | output | 1 | Infrared transmit pin |
| dtr_n | output | 1 | Data terminal ready pin |
| rts_n | output | 1 | Request to send pin |
| out1_n | output | 1 | User output 1 pin |
| out2_n | output | 1 | User output 2 pin |
| rx_serial | output | 1 | Serial data to the receiver |
| ir_rx | output | 1 | Infrared data to the receiver |
| dsr_n_int | output | 1 | Data set ready to the modem status logic |
| cts_n_int | output | 1 | Clear to send to the modem status logic |
| ri_n_int | output | 1 | Ring indicator to the modem status logic |
| dcd_n_int | output | 1 | Carrier detect to the modem status logic |

## Verification
The control word is the only long-lived state apart from the synchronizer. A wrong stored bit shows on rd_data and on the matching pin one cycle after the write, and it stays there until the next write. A fault in the synchronizer shows as status outputs that arrive one edge early or late relative to the external inputs, or that appear while loopback should be hiding them. The scoreboard compares every output on every cycle, so such an error is reported on the first cycle it reaches the ports.

// File: rtl/uart_mc_pkg.sv
package uart_mc_pkg;
    localparam int unsigned MC_REG_W   = 16;
    localparam int unsigned MC_USED_W  = 7;
    localparam int unsigned MC_STATUS_W = 4;
    localparam int unsigned MC_SYNC_STAGES = 2;

    // Bit positions in the control word; software decodes these.
    localparam int unsigned BIT_DTR  = 0;
    localparam int unsigned BIT_RTS  = 1;
    localparam int unsigned BIT_OUT1 = 2;
    localparam int unsigned BIT_OUT2 = 3;
    localparam int unsigned BIT_LOOP = 4;
    localparam int unsigned BIT_AFC  = 5;
    localparam int unsigned BIT_IR   = 6;

    typedef struct packed {
        logic ir_mode;
        logic auto_flow;
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } mc_ctrl_t;

    // Status vector order: {dcd, ri, cts, dsr}, all active low
    typedef struct packed {
        logic dcd_n;
        logic ri_n;
        logic cts_n;
        logic dsr_n;
    } mc_status_t;
endpackage

// File: rtl/uart_mc_ctrl_reg.sv
module uart_mc_ctrl_reg
    import uart_mc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [MC_REG_W-1:0] wr_data,
    output mc_ctrl_t            ctrl,
    output logic [MC_REG_W-1:0] rd_data
);
    localparam int unsigned PAD_W = MC_REG_W - MC_USED_W;

    typedef struct packed {
        mc_ctrl_t word;
    } reg_state_t;

    reg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.word = mc_ctrl_t'(wr_data[MC_USED_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctrl    = state_q.word;
    assign rd_data = {{PAD_W{1'b0}}, state_q.word};
endmodule

// File: rtl/uart_mc_sync.sv
module uart_mc_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[g] <= '1;
            end else begin
                stage_q[g] <= stage_d[g];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/uart_mc_pin_mux.sv
module uart_mc_pin_mux
    import uart_mc_pkg::*;
(
    input  mc_ctrl_t   ctrl,
    input  logic       fifo_en,
    input  logic       rx_above_trig,
    input  logic       ser_tx,
    input  logic       ir_tx_n,
    input  logic       sin,
    input  logic       sir_in,
    input  mc_status_t ext_sync,
    output logic       sout,
    output logic       sir_out_n,
    output logic       dtr_n,
    output logic       rts_n,
    output logic       out1_n,
    output logic       out2_n,
    output logic       rx_serial,
    output logic       ir_rx,
    output mc_status_t status_int
);
    logic       flow_stop;
    mc_status_t looped;

    always_comb begin
        flow_stop = ctrl.auto_flow & fifo_en & rx_above_trig;

        looped.dsr_n = ~ctrl.dtr;
        looped.cts_n = ~ctrl.rts;
        looped.ri_n  = ~ctrl.out1;
        looped.dcd_n = ~ctrl.out2;

        if (ctrl.loop) begin
            sout       = 1'b1;
            sir_out_n  = 1'b0;
            dtr_n      = 1'b1;
            rts_n      = 1'b1;
            out1_n     = 1'b1;
            out2_n     = 1'b1;
            rx_serial  = ctrl.ir_mode ? 1'b1 : ser_tx;
            ir_rx      = ctrl.ir_mode ? ~ir_tx_n : 1'b0;
            status_int = looped;
        end else begin
            sout       = ser_tx;
            sir_out_n  = ir_tx_n;
            dtr_n      = ~ctrl.dtr;
            rts_n      = ~(ctrl.rts & ~flow_stop);
            out1_n     = ~ctrl.out1;
            out2_n     = ~ctrl.out2;
            rx_serial  = sin;
            ir_rx      = sir_in;
            status_int = ext_sync;
        end
    end
endmodule

// File: rtl/uart_modem_ctrl.sv
module uart_modem_ctrl
    import uart_mc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [MC_REG_W-1:0] wr_data,
    output logic [MC_REG_W-1:0] rd_data,
    input  logic                fifo_en,
    input  logic                rx_above_trig,
    input  logic                ser_tx,
    input  logic                ir_tx_n,
    input  logic                sin,
    input  logic                sir_in,
    input  logic                dsr_n,
    input  logic                cts_n,
    input  logic                ri_n,
    input  logic                dcd_n,
    output logic                sout,
    output logic                sir_out_n,
    output logic                dtr_n,
    output logic                rts_n,
    output logic                out1_n,
    output logic                out2_n,
    output logic                rx_serial,
    output logic                ir_rx,
    output logic                dsr_n_int,
    output logic                cts_n_int,
    output logic                ri_n_int,
    output logic                dcd_n_int
);
    mc_ctrl_t   ctrl;
    mc_status_t ext_raw;
    mc_status_t ext_sync;
    mc_status_t status_int;

    assign ext_raw = '{dcd_n: dcd_n, ri_n: ri_n, cts_n: cts_n, dsr_n: dsr_n};

    uart_mc_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .rd_data (rd_data)
    );

    uart_mc_sync #(
        .WIDTH  (MC_STATUS_W),
        .STAGES (MC_SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ext_raw),
        .dout  (ext_sync)
    );

    uart_mc_pin_mux u_mux (
        .ctrl          (ctrl),
        .fifo_en       (fifo_en),
        .rx_above_trig (rx_above_trig),
        .ser_tx        (ser_tx),
        .ir_tx_n       (ir_tx_n),
        .sin           (sin),
        .sir_in        (sir_in),
        .ext_sync      (ext_sync),
        .sout          (sout),
        .sir_out_n     (sir_out_n),
        .dtr_n         (dtr_n),
        .rts_n         (rts_n),
        .out1_n        (out1_n),
        .out2_n        (out2_n),
        .rx_serial     (rx_serial),
        .ir_rx         (ir_rx),
        .status_int    (status_int)
    );

    assign dsr_n_int = status_int.dsr_n;
    assign cts_n_int = status_int.cts_n;
    assign ri_n_int  = status_int.ri_n;
    assign dcd_n_int = status_int.dcd_n;
endmodule

// File: rtl/uart_modem_ctrl_chk.sv
module uart_modem_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic [15:0] rd_data,
    input logic        fifo_en,
    input logic        rx_above_trig,
    input logic        ser_tx,
    input logic        ir_tx_n,
    input logic        dsr_n,
    input logic        cts_n,
    input logic        ri_n,
    input logic        dcd_n,
    input logic        sout,
    input logic        sir_out_n,
    input logic        dtr_n,
    input logic        rts_n,
    input logic        out1_n,
    input logic        out2_n,
    input logic        rx_serial,
    input logic        ir_rx,
    input logic        dsr_n_int,
    input logic        cts_n_int,
    input logic        ri_n_int,
    input logic        dcd_n_int
);
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    assert_write_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == {9'b0, $past(wr_data[6:0])});

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[15:7] == 9'b0);

    assert_flow_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[4] && rd_data[5] && fifo_en && rx_above_trig) |-> rts_n);

    assert_pins_parked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[4] |-> (dtr_n && rts_n && out1_n && out2_n));

    assert_uart_loop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[4] && !rd_data[6]) |-> (sout && !sir_out_n && rx_serial == ser_tx && !ir_rx));

    assert_ir_loop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[4] && rd_data[6]) |-> (sout && !sir_out_n && ir_rx == !ir_tx_n && rx_serial));

    assert_loop_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[4] |-> ({dcd_n_int, ri_n_int, cts_n_int, dsr_n_int} == ~rd_data[3:0]));

    assert_sync_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && !rd_data[4]) |->
        ({dcd_n_int, ri_n_int, cts_n_int, dsr_n_int} ==
         {$past(dcd_n, 2), $past(ri_n, 2), $past(cts_n, 2), $past(dsr_n, 2)}));
endmodule

bind uart_modem_ctrl uart_modem_ctrl_chk u_chk (.*);

// File: tb/tb_uart_modem_ctrl.sv
`timescale 1ns/1ps
module tb_uart_modem_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        fifo_en = 1'b0, rx_above_trig = 1'b0;
    logic        ser_tx = 1'b1, ir_tx_n = 1'b1, sin = 1'b1, sir_in = 1'b0;
    logic        dsr_n = 1'b1, cts_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
    logic        sout, sir_out_n, dtr_n, rts_n, out1_n, out2_n, rx_serial, ir_rx;
    logic        dsr_n_int, cts_n_int, ri_n_int, dcd_n_int;

    always #2 clk = ~clk;

    uart_modem_ctrl dut (.*);

    // staged stimulus, applied by the driver task
    logic        s_we = 0;
    logic [15:0] s_wd = '0;
    logic        s_fe = 0, s_ab = 0, s_tx = 1, s_irt = 1, s_sin = 1, s_sir = 0;
    logic [3:0]  s_ext = 4'hF;   // {dcd, ri, cts, dsr}

    // reference model state
    logic [6:0]  m_reg = '0;
    logic [3:0]  m_s1 = 4'hF, m_s2 = 4'hF;

    logic [27:0] exp_q [$];
    string       tag_q [$];
    int          checks = 0, bad = 0;
    bit          done = 0;

    function automatic logic [27:0] actual_vec();
        return {rd_data, sout, sir_out_n, dtr_n, rts_n, out1_n, out2_n,
                rx_serial, ir_rx, dcd_n_int, ri_n_int, cts_n_int, dsr_n_int};
    endfunction

    function automatic logic [27:0] model_vec();
        logic lp, ir, afc;
        logic e_sout, e_sir, e_dtr, e_rts, e_o1, e_o2, e_rx, e_irx;
        logic [3:0] e_st;
        lp = m_reg[4]; ir = m_reg[6]; afc = m_reg[5];
        if (lp) begin
            e_sout = 1; e_sir = 0; e_dtr = 1; e_rts = 1; e_o1 = 1; e_o2 = 1;
            e_rx  = ir ? 1'b1 : s_tx;
            e_irx = ir ? ~s_irt : 1'b0;
            e_st  = ~m_reg[3:0];
        end else begin
            e_sout = s_tx; e_sir = s_irt;
            e_dtr = ~m_reg[0];
            e_rts = ~(m_reg[1] & ~(afc & s_fe & s_ab));
            e_o1 = ~m_reg[2]; e_o2 = ~m_reg[3];
            e_rx = s_sin; e_irx = s_sir;
            e_st = m_s2;
        end
        return {9'b0, m_reg, e_sout, e_sir, e_dtr, e_rts, e_o1, e_o2, e_rx, e_irx, e_st};
    endfunction

    // driver: apply staged inputs away from the edge, model the edge, push expectation
    task automatic cyc(input string tag);
        @(negedge clk); #1;
        wr_en = s_we; wr_data = s_wd; fifo_en = s_fe; rx_above_trig = s_ab;
        ser_tx = s_tx; ir_tx_n = s_irt; sin = s_sin; sir_in = s_sir;
        {dcd_n, ri_n, cts_n, dsr_n} = s_ext;
        @(posedge clk);
        if (s_we) m_reg = s_wd[6:0];
        m_s2 = m_s1; m_s1 = s_ext;
        exp_q.push_back(model_vec());
        tag_q.push_back(tag);
        s_we = 0;
    endtask

    task automatic wr(input logic [15:0] v, input string tag);
        s_we = 1; s_wd = v; cyc(tag);
    endtask

    // monitor
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [27:0] e, a;
            string t;
            e = exp_q.pop_front(); t = tag_q.pop_front(); a = actual_vec();
            checks++;
            if (a !== e) begin
                bad++;
                $display("FAIL %s actual=%h expected=%h", t, a, e);
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            bad++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state while reset is held
        repeat (3) @(negedge clk);
        checks++;
        if ({rd_data, dtr_n, rts_n, out1_n, out2_n} !== {16'h0, 4'hF}) begin
            bad++;
            $display("FAIL R1 actual=%h expected=%h", {rd_data, dtr_n, rts_n, out1_n, out2_n}, {16'h0, 4'hF});
        end
        #1 rst_n = 1;
        cyc("R1"); cyc("R1");

        // R2: upper bits ignored, lower bits stored
        wr(16'hFF8B, "R2"); cyc("R2");
        wr(16'hFF80, "R2");
        // R3: each control pin
        wr(16'h0001, "R3"); wr(16'h0002, "R3"); wr(16'h0004, "R3"); wr(16'h0008, "R3");
        wr(16'h000F, "R3");
        // R5: data paths in normal mode
        wr(16'h0000, "R5");
        s_tx = 0; cyc("R5"); s_irt = 0; cyc("R5"); s_sin = 0; cyc("R5"); s_sir = 1; cyc("R5");
        s_tx = 1; s_irt = 1; s_sin = 1; s_sir = 0; cyc("R5");
        // R4: auto flow gating
        wr(16'h0022, "R4");
        s_fe = 1; s_ab = 1; cyc("R4");
        s_ab = 0; cyc("R4");
        s_fe = 0; s_ab = 1; cyc("R4");
        s_fe = 1; wr(16'h0002, "R4");
        wr(16'h0022, "R4"); s_ab = 0; cyc("R4");
        // R10: synchronizer delay
        wr(16'h0000, "R10");
        s_ext = 4'hA; cyc("R10"); s_ext = 4'h5; cyc("R10"); cyc("R10"); cyc("R10");
        s_ext = 4'h0; cyc("R10"); cyc("R10"); cyc("R10");
        // R6 and R8: UART loopback
        wr(16'h001F, "R8");
        s_tx = 0; cyc("R6"); s_tx = 1; cyc("R6"); s_sin = 0; cyc("R6"); s_sin = 1;
        // R9: ext inputs ignored, looped status
        s_ext = 4'hF; cyc("R9"); s_ext = 4'h3; cyc("R9");
        wr(16'h0015, "R9"); wr(16'h001A, "R9"); wr(16'h0010, "R9");
        // R9 with auto flow stop active: looped RTS not gated
        s_fe = 1; s_ab = 1; wr(16'h0032, "R9"); s_ab = 0;
        // R7: infrared loopback
        wr(16'h005F, "R7");
        s_irt = 0; cyc("R7"); s_irt = 1; cyc("R7"); s_tx = 0; cyc("R7"); s_tx = 1;
        s_sir = 1; cyc("R7"); s_sir = 0;
        // leave loopback: synchronized external inputs return (R10)
        s_ext = 4'h6; cyc("R9");
        wr(16'h0040, "R10"); cyc("R10"); cyc("R10");
        wr(16'h0000, "R5"); cyc("R5");
        repeat (3) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule